// File: doc/BRIEF.md
# Word-Wide Receive Buffer with Status Flags

This block holds up to 32 received 32-bit serial-bus words between the logic that accepts words and a host read port. Each cycle with `push` high stores `push_word` at the tail. Each cycle with `pop` high moves the oldest word into the registered `pop_word` output. Three status outputs report empty, half-full (16 or more words) and full (32 words). A single flag output shows one of those conditions, or "at least one word available", as chosen by a 2-bit select input.

When the buffer is full and a word arrives with no pop in the same cycle, the block does not drop the word. It writes the word over the newest stored entry, which sits in the last occupied slot. The count stays at 32. If a pop comes in the same cycle, the pop is done first and the new word takes the freed place, so nothing is overwritten. All state changes on the rising clock edge. Reset is synchronous and active high.

Top module: `rx_word_fifo`

## Requirements
- R1: Words leave in the order they were written. A pop on a non-empty buffer places the oldest word on `pop_word` from the clock edge that performs the pop, and all 32 bits are kept.
- R2: With zero words held, `is_empty`=1, `is_half`=0 and `is_full`=0.
- R3: After a push into an empty buffer, `is_empty` is 0 from the next clock edge.
- R4: `is_half` is 1 exactly when 16 or more words are held: 0 at 15 words and 1 at 16 words.
- R5: `is_full` is 1 exactly when 32 words are held. A push while full with no pop replaces the newest word and leaves the count at 32. The oldest 31 words are not changed.
- R6: `flag_out` follows `flag_sel` combinationally: 2'b00 gives empty, 2'b01 gives half-full, 2'b10 gives full, and 2'b11 gives not-empty.
- R7: The status outputs reflect the word count after every clock edge, for any mix of pushes and pops.
- R8: A pop on an empty buffer with no push leaves `pop_word` unchanged, and the buffer stays empty.
- R9: A push and a pop in the same cycle on a buffer that is neither empty nor full leave the count unchanged. The pop returns the oldest word and the pushed word joins the tail.
- R10: A push and a pop in the same cycle on a full buffer pop the oldest word first and then append the new word. The count stays at 32 and no stored word is overwritten.
- R11: A synchronous reset empties the buffer (empty=1) and clears `pop_word` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Store `push_word` this cycle |
| push_word | input | 32 | Accepted received word |
| pop | input | 1 | Remove the oldest word this cycle |
| pop_word | output | 32 | Last word removed (registered) |
| flag_sel | input | 2 | Flag source: 00 empty, 01 half, 10 full, 11 not-empty |
| is_empty | output | 1 | No words held |
| is_half | output | 1 | 16 or more words held |
| is_full | output | 1 | 32 words held |
| flag_out | output | 1 | Selected status condition |

## Verification
The bench builds the block with its default parameters: 32-bit words, 32 entries and a half mark of 16. These values are what the requirements name, and they let the bench reach the 15/16 half-full boundary and the full state within a few dozen cycles. Overwrite while full, the pop-then-push case at full, and pops on an empty buffer are each driven on purpose. A pseudo-random mix of pushes and pops then moves the count across every status boundary. Throughout, the bench compares the block against a queue model on every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef enum logic [1:0] {
      FSEL_EMPTY = 2'b00,
      FSEL_HALF  = 2'b01,
      FSEL_FULL  = 2'b10,
      FSEL_AVAIL = 2'b11
   } flag_src_e;
endpackage

// File: rtl/rxf_ptr_ctrl.sv
// Pointer and occupancy control; decides where a write lands.
module rxf_ptr_ctrl #(
   parameter int DEPTH = 32,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   output logic          store_en,
   output logic [AW-1:0] store_addr,
   output logic          take_en,
   output logic [AW-1:0] take_addr,
   output logic [CW-1:0] level
);
   logic [AW-1:0] head_q, tail_q;
   logic [CW-1:0] level_q;
   logic          full_now, empty_now, replace, advance_tail;

   always_comb begin
      full_now     = (level_q == CW'(DEPTH));
      empty_now    = (level_q == '0);
      take_en      = pop && !empty_now;
      replace      = push && full_now && !pop;
      advance_tail = push && !replace;
      store_en     = push;
      store_addr   = replace ? (tail_q - AW'(1)) : tail_q;
      take_addr    = head_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         head_q  <= '0;
         tail_q  <= '0;
         level_q <= '0;
      end else begin
         if (take_en)      head_q <= head_q + AW'(1);
         if (advance_tail) tail_q <= tail_q + AW'(1);
         if (advance_tail && !take_en)      level_q <= level_q + CW'(1);
         else if (take_en && !advance_tail) level_q <= level_q - CW'(1);
      end
   end

   assign level = level_q;
endmodule

// File: rtl/rxf_store.sv
// Word storage with registered read port.
module rxf_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] slot_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (we && (waddr == AW'(i))) slot_q[i] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)     rdata <= '0;
      else if (re) rdata <= slot_q[raddr];
   end
endmodule

// File: rtl/rxf_status.sv
// Status decode and selectable flag output.
module rxf_status #(
   parameter int DEPTH     = 32,
   parameter int HALF_MARK = DEPTH / 2,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic [CW-1:0] level,
   input  logic [1:0]    flag_sel,
   output logic          is_empty,
   output logic          is_half,
   output logic          is_full,
   output logic          flag_out
);
   import rxf_pkg::*;
   flag_src_e src;

   always_comb begin
      is_empty = (level == '0);
      is_half  = (level >= CW'(HALF_MARK));
      is_full  = (level == CW'(DEPTH));
      src      = flag_src_e'(flag_sel);
      unique case (src)
         FSEL_EMPTY: flag_out = is_empty;
         FSEL_HALF:  flag_out = is_half;
         FSEL_FULL:  flag_out = is_full;
         FSEL_AVAIL: flag_out = !is_empty;
         default:    flag_out = 1'b0;
      endcase
   end
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
   parameter int DATA_W    = 32,
   parameter int DEPTH     = 32,
   parameter int HALF_MARK = DEPTH / 2,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [DATA_W-1:0] push_word,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_word,
   input  logic [1:0]        flag_sel,
   output logic              is_empty,
   output logic              is_half,
   output logic              is_full,
   output logic              flag_out
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("rx_word_fifo: DEPTH must be a power of two >= 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rx_word_fifo: DATA_W must be positive");
   end
   if (HALF_MARK < 1 || HALF_MARK > DEPTH) begin : g_bad_half
      $error("rx_word_fifo: HALF_MARK out of range");
   end

   logic          store_en, take_en;
   logic [AW-1:0] store_addr, take_addr;
   logic [CW-1:0] level;

   rxf_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst(rst), .push(push), .pop(pop),
      .store_en(store_en), .store_addr(store_addr),
      .take_en(take_en), .take_addr(take_addr), .level(level)
   );

   rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst(rst), .we(store_en), .waddr(store_addr),
      .wdata(push_word), .re(take_en), .raddr(take_addr), .rdata(pop_word)
   );

   rxf_status #(.DEPTH(DEPTH), .HALF_MARK(HALF_MARK)) u_stat (
      .level(level), .flag_sel(flag_sel),
      .is_empty(is_empty), .is_half(is_half), .is_full(is_full),
      .flag_out(flag_out)
   );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              push,
   input logic              pop,
   input logic [DATA_W-1:0] pop_word,
   input logic [1:0]        flag_sel,
   input logic              is_empty,
   input logic              is_half,
   input logic              is_full,
   input logic              flag_out
);
   p_empty_clean_r2: assert property (@(posedge clk) disable iff (rst)
      is_empty |-> (!is_half && !is_full));

   p_push_not_empty_r3: assert property (@(posedge clk) disable iff (rst)
      push |=> !is_empty);

   p_full_has_half_r4: assert property (@(posedge clk) disable iff (rst)
      is_full |-> is_half);

   p_full_sticks_r5: assert property (@(posedge clk) disable iff (rst)
      (is_full && push && !pop) |=> is_full);

   p_flag_avail_r6: assert property (@(posedge clk) disable iff (rst)
      (flag_sel == 2'b11) |-> (flag_out == !is_empty));

   p_empty_pop_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (is_empty && pop && !push) |=> ($stable(pop_word) && is_empty));

   p_full_swap_r10: assert property (@(posedge clk) disable iff (rst)
      (is_full && push && pop) |=> is_full);

   p_reset_empty_r11: assert property (@(posedge clk)
      rst |=> (is_empty && pop_word == '0));
endmodule

bind rx_word_fifo rxf_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .push(push), .pop(pop), .pop_word(pop_word),
   .flag_sel(flag_sel), .is_empty(is_empty), .is_half(is_half),
   .is_full(is_full), .flag_out(flag_out)
);

// File: tb/tb_rx_word_fifo.sv
`timescale 1ns/1ps
module tb_rx_word_fifo;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        push = 1'b0;
   logic [31:0] push_word = '0;
   logic        pop = 1'b0;
   logic [1:0]  flag_sel = 2'b00;
   logic [31:0] pop_word;
   logic        is_empty, is_half, is_full, flag_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   logic [31:0] mq[$];
   logic [31:0] m_out = '0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   always #5 clk = ~clk;

   rx_word_fifo dut (
      .clk(clk), .rst(rst), .push(push), .push_word(push_word), .pop(pop),
      .pop_word(pop_word), .flag_sel(flag_sel), .is_empty(is_empty),
      .is_half(is_half), .is_full(is_full), .flag_out(flag_out)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // one clock: inputs already set; model updates at the edge; compare at negedge
   task automatic step(input string tag);
      int  n;
      logic e, h, f, fl;
      @(posedge clk);
      if (rst) begin
         mq.delete();
         m_out = '0;
      end else begin
         n = mq.size();
         if (pop && n > 0) m_out = mq.pop_front();
         if (push) begin
            if (n == 32 && !pop) mq[31] = push_word;
            else mq.push_back(push_word);
         end
      end
      @(negedge clk);
      e = (mq.size() == 0);
      h = (mq.size() >= 16);
      f = (mq.size() == 32);
      case (flag_sel)
         2'b00: fl = e;
         2'b01: fl = h;
         2'b10: fl = f;
         default: fl = !e;
      endcase
      check({tag, " status"}, {28'd0, is_empty, is_half, is_full, flag_out}, {28'd0, e, h, f, fl});
      check({tag, " data"}, pop_word, m_out);
   endtask

   task automatic drive(input logic w, input logic [31:0] d, input logic r, input string tag);
      push = w; push_word = d; pop = r;
      step(tag);
      push = 1'b0; pop = 1'b0;
   endtask

   initial begin
      #(200_000 * 10);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      rst = 1'b1; step("R11 reset"); step("R2 reset state");
      rst = 1'b0;
      drive(1'b0, '0, 1'b1, "R8 pop on empty");
      drive(1'b1, 32'hA5A5_0001, 1'b0, "R3 first push");
      flag_sel = 2'b11; drive(1'b0, '0, 1'b0, "R6 avail flag");
      for (int i = 2; i <= 16; i++) begin
         flag_sel = 2'b01;
         drive(1'b1, 32'hC000_0000 + i, 1'b0, (i < 16) ? "R4 below mark" : "R4 at mark");
      end
      for (int i = 17; i <= 32; i++) begin
         flag_sel = 2'b10;
         drive(1'b1, {i[7:0], 24'h5A5A5A}, 1'b0, "R5 fill");
      end
      drive(1'b1, 32'hDEAD_0031, 1'b0, "R5 overwrite newest");
      drive(1'b1, 32'hDEAD_0032, 1'b0, "R5 overwrite again");
      for (int s = 0; s < 4; s++) begin
         flag_sel = s[1:0]; drive(1'b0, '0, 1'b0, "R6 select at full");
      end
      drive(1'b1, 32'hF00D_0001, 1'b1, "R10 pop then push at full");
      drive(1'b1, 32'hF00D_0002, 1'b1, "R10 second swap");
      for (int i = 0; i < 10; i++) drive(1'b0, '0, 1'b1, "R1 drain order");
      for (int i = 0; i < 4; i++) drive(1'b1, 32'hBEEF_0000 + i, 1'b1, "R9 concurrent mid");
      flag_sel = 2'b00;
      for (int i = 0; i < 30; i++) drive(1'b0, '0, 1'b1, "R1 drain to empty");
      drive(1'b0, '0, 1'b1, "R8 pop on empty again");
      drive(1'b1, 32'h1234_5678, 1'b1, "R9 push+pop on empty");
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         flag_sel = lfsr[9:8];
         drive(lfsr[3] | (i % 200 < 80 ? lfsr[5] : 1'b0), lfsr ^ 32'h0F0F_1234,
               lfsr[6] & (i % 200 >= 60 ? 1'b1 : lfsr[7]), "R7 mixed traffic");
      end
      rst = 1'b1; step("R11 reset mid-fill"); rst = 1'b0;
      drive(1'b0, '0, 1'b0, "R2 after reset");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule